// File: doc/BRIEF.md
# Caption Slicer Interrupt Selector

This block raises the data-slicer interrupt request for a closed-caption decoder. The capture logic reports three kinds of event for each of two slice lines, main and sub: the end of the line, completion of a 16-clock data capture, and the number of clock run-in pulses it counted. Configuration bits pick one line and one kind of event. When that event occurs, the block issues a single-cycle request to the processor-side interrupt controller.

Only one request is issued per field. After the request, the block ignores further events until vertical sync falls, which arms it again. Events on the line that is not selected never cause a request. Everything on the input side is a plain strobe or a level, and the output is a plain pulse. There is no data stream, so no valid/ready handshake is used.

Top module: `slicer_irq_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `irq` is low. The block leaves reset armed.
- R2: With `cfg_src` = 00 (end of line), `irq` goes high in the cycle after the selected line's end-of-line strobe is sampled, provided the block is armed.
- R3: With `cfg_src` = 01 (capture with run-in check), a capture-done strobe on the selected line raises `irq` one cycle later only if that line's run-in count lies between 4 and 6, inclusive. Any other count gives no request.
- R4: With `cfg_src` = 10 or 11 (capture only), a capture-done strobe on the selected line raises `irq` one cycle later, whatever the run-in count.
- R5: `cfg_line_sel` = 0 selects the main line and 1 selects the sub line. Strobes on the line that is not selected never raise `irq`.
- R6: After a request, no further request is issued until the block is re-armed.
- R7: A falling edge on `vsync` re-arms the block. A rising edge, or `vsync` staying at one level, does not.
- R8: Every request lasts exactly one clock cycle.
- R9: Strobes of a kind the selected source does not use are ignored. An end-of-line strobe is ignored in the capture modes, and a capture-done strobe is ignored in the end-of-line mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Vertical sync level; a falling edge re-arms the block |
| cfg_line_sel | input | 1 | 0 = main line, 1 = sub line |
| cfg_src | input | 2 | 00 end of line, 01 capture plus run-in window, 1x capture only |
| main_eol | input | 1 | End-of-line strobe for the main line |
| main_cap_done | input | 1 | 16-clock capture complete on the main line |
| main_runin_cnt | input | CNT_W | Run-in pulse count on the main line |
| sub_eol | input | 1 | End-of-line strobe for the sub line |
| sub_cap_done | input | 1 | 16-clock capture complete on the sub line |
| sub_runin_cnt | input | CNT_W | Run-in pulse count on the sub line |
| irq | output | 1 | Single-cycle interrupt request |

## Verification
The assertions assume that the configuration bits do not change in the cycle an event strobe arrives. They also assume that the run-in count is valid whenever a capture-done strobe is high. The bench follows both rules. It sets the configuration while no strobe is active, and it drives each count together with its strobe for one whole clock. Every sweep step starts with a complete vsync high-then-low sequence, so each step begins armed and none depends on what the previous step left behind.

// File: rtl/slint_pkg.sv
package slint_pkg;
  typedef enum logic [1:0] {
    SRC_EOL     = 2'b00,
    SRC_RUNIN   = 2'b01,
    SRC_CAP     = 2'b10,
    SRC_CAP_ALT = 2'b11
  } src_e;
endpackage

// File: rtl/slint_evt_sel.sv
module slint_evt_sel
  import slint_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int RUNIN_MIN = 4,
  parameter int RUNIN_MAX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_e             src,
  input  logic             eol,
  input  logic             cap,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] LO = RUNIN_MIN[CNT_W-1:0];
  localparam logic [CNT_W-1:0] HI = RUNIN_MAX[CNT_W-1:0];

  logic in_win;
  assign in_win = (cnt >= LO) && (cnt <= HI);

  always_comb begin
    case (src)
      SRC_EOL:   hit = eol;
      SRC_RUNIN: hit = cap & in_win;
      default:   hit = cap;
    endcase
  end

  // R3
  runin_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_RUNIN && (cnt < LO || cnt > HI)) |-> !hit);

  // R9
  eol_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src != SRC_EOL && !cap) |-> !hit);
endmodule

// File: rtl/slint_arm.sv
module slint_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  input  logic hit,
  output logic irq
);
  logic vs_q;
  logic armed;
  logic vs_fall;
  logic fire;

  assign vs_fall = vs_q & ~vsync;
  assign fire    = armed & hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q  <= 1'b0;
      armed <= 1'b1;
      irq   <= 1'b0;
    end else begin
      vs_q <= vsync;
      irq  <= fire;
      if (vs_fall)   armed <= 1'b1;
      else if (fire) armed <= 1'b0;
    end
  end

  // R8
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !vs_fall) |=> !irq);

  // R7
  fall_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_fall |=> armed);
endmodule

// File: rtl/slicer_irq_sel.sv
module slicer_irq_sel
  import slint_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int RUNIN_MIN = 4,
  parameter int RUNIN_MAX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync,
  input  logic             cfg_line_sel,
  input  logic [1:0]       cfg_src,
  input  logic             main_eol,
  input  logic             main_cap_done,
  input  logic [CNT_W-1:0] main_runin_cnt,
  input  logic             sub_eol,
  input  logic             sub_cap_done,
  input  logic [CNT_W-1:0] sub_runin_cnt,
  output logic             irq
);
  localparam int NLINES = 2;

  src_e             src;
  logic [NLINES-1:0] eol_v, cap_v, hit_v;
  logic [CNT_W-1:0]  cnt_v [NLINES];
  logic              sel_hit;

  assign src      = src_e'(cfg_src);
  assign eol_v    = {sub_eol, main_eol};
  assign cap_v    = {sub_cap_done, main_cap_done};
  assign cnt_v[0] = main_runin_cnt;
  assign cnt_v[1] = sub_runin_cnt;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    slint_evt_sel #(
      .CNT_W(CNT_W), .RUNIN_MIN(RUNIN_MIN), .RUNIN_MAX(RUNIN_MAX)
    ) u_sel (
      .clk(clk), .rst_n(rst_n), .src(src),
      .eol(eol_v[g]), .cap(cap_v[g]), .cnt(cnt_v[g]), .hit(hit_v[g])
    );
  end

  assign sel_hit = hit_v[cfg_line_sel];

  slint_arm u_arm (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .hit(sel_hit), .irq(irq)
  );

  // R5
  line_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cfg_line_sel ? (sub_eol | sub_cap_done)
                               : (main_eol | main_cap_done)));

  // R1
  reset_low_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !irq);
endmodule

// File: tb/slicer_irq_sel_tb.sv
`timescale 1ns/1ps
module slicer_irq_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync = 1'b0;
  logic       line_sel = 1'b0;
  logic [1:0] src = 2'b00;
  logic       m_eol = 1'b0, m_cap = 1'b0, s_eol = 1'b0, s_cap = 1'b0;
  logic [3:0] m_cnt = 4'd0, s_cnt = 4'd0;
  logic       irq;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  slicer_irq_sel dut_i (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .cfg_line_sel(line_sel),
    .cfg_src(src), .main_eol(m_eol), .main_cap_done(m_cap),
    .main_runin_cnt(m_cnt), .sub_eol(s_eol), .sub_cap_done(s_cap),
    .sub_runin_cnt(s_cnt), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s irq=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic rearm();
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    @(negedge clk);
  endtask

  // One-clock strobe; returns irq as seen one cycle after the event edge.
  task automatic strobe(input int ln, input int kind, input logic [3:0] c,
                        output logic seen);
    if (ln == 0) begin m_eol = (kind != 1); m_cap = (kind != 0); m_cnt = c; end
    else         begin s_eol = (kind != 1); s_cap = (kind != 0); s_cnt = c; end
    @(negedge clk);
    m_eol = 0; m_cap = 0; s_eol = 0; s_cap = 0;
    seen = irq;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic seen;
    repeat (3) @(negedge clk);
    check("R1", irq, 1'b0);
    // Event while in reset must not fire.
    m_eol = 1'b1;
    @(negedge clk);
    m_eol = 1'b0;
    rst_n = 1'b1;
    check("R1", irq, 1'b0);
    // Armed out of reset: fires without any vsync edge.
    strobe(0, 0, 4'd0, seen);
    check("R1", seen, 1'b1);
    @(negedge clk);

    for (int ls = 0; ls < 2; ls++)
      for (int sv = 0; sv < 4; sv++)
        for (int el = 0; el < 2; el++)
          for (int kind = 0; kind < 3; kind++)
            for (int c = 0; c < 16; c++) begin
              logic exp;
              string tag;
              line_sel = ls[0];
              src = sv[1:0];
              rearm();
              exp = 1'b0;
              if (el == ls) begin
                if (sv == 0) exp = (kind != 1);
                else if (sv == 1) exp = (kind != 0) && c >= 4 && c <= 6;
                else exp = (kind != 0);
              end
              if (el != ls) tag = "R5";
              else if (sv == 0) tag = (kind == 1) ? "R9" : "R2";
              else if (sv == 1) tag = "R3";
              else tag = (kind == 0) ? "R9" : "R4";
              strobe(el, kind, c[3:0], seen);
              check(tag, seen, exp);
              @(negedge clk);
              check("R8", irq, 1'b0);
              if (exp) begin
                strobe(el, kind, c[3:0], seen);
                check("R6", seen, 1'b0);
              end
            end

    // R7: rising vsync does not re-arm; falling does.
    line_sel = 1'b1;
    src = 2'b10;
    rearm();
    strobe(1, 1, 4'd9, seen);
    check("R7", seen, 1'b1);
    vsync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    strobe(1, 1, 4'd9, seen);
    check("R7", seen, 1'b0);
    vsync = 1'b0;
    @(negedge clk);
    strobe(1, 1, 4'd9, seen);
    check("R7", seen, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule